// File: doc/BRIEF.md
# Fuse Programming Controller with Shadow Copies

This block sits between a 32-bit register port and a small one-time-programmable fuse array. The array is held as a bank of registers. Software selects a fuse word and loads an unlock key into the control register. It then writes the data register. That data write starts a timed program cycle. Programming can only set fuse bits, so the new fuse word is the old word ORed with the data.

Reads of fuse contents do not go to the array. They go through read-only shadow copies. The shadow copies change only when software asks for a reload. A reload walks every fuse word in order and copies it into its shadow. A busy flag covers both the program cycle and the reload. An error flag records program requests that were refused. A bit-set alias of the control register lets software set single bits, such as the reload request, without rewriting the whole control register.

Top module: `fuse_ctl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, the timing register (0x10) reads 0x0002_2010, the data register (0x20) reads 0, and every shadow word reads 0.
- R2: The control register holds these fields: word address in bits [6:0], busy in bit 8, error in bit 9, reload request in bit 10, and unlock key in bits [31:16]. Every write to the data register clears the key field to 0, whether or not a program cycle starts.
- R3: A write to offset 0x04 ORs the written address bits, reload bit and key bits into the control register. All other bits keep their values.
- R4: A data write starts a program cycle only when all of these hold: the key field equals 0x3E77, busy is 0, error is 0, and the word address is below 64. In every other case error becomes 1 and the fuse array is unchanged. A request that arrives in the last busy cycle of a reload is refused.
- R5: A program cycle keeps busy at 1 for 2*relax + strobe clock cycles, starting in the cycle after the data write. The total is at least 1 cycle.
- R6: Programming sets a fuse word to its old value ORed with the written data.
- R7: Shadow words keep their values through a program cycle and change only during a reload.
- R8: Writing 1 to bit 10 starts a reload. The reload keeps busy at 1 for 64 × max(read strobe, 1) cycles. Bit 10 reads 0 again once the reload ends.
- R9: Shadow word n is read at 0x400 + n*0x10 for n < 48, and at 0x500 + n*0x10 for 48 ≤ n < 64. The unmapped gap 0x700–0x7F0, unaligned offsets and other addresses read 0.
- R10: While error is 1, data writes start no program cycle and leave busy at 0. Writing 1 to bit 9 at offset 0x00 clears error.
- R11: The timing register holds the strobe width in bits [11:0], the relax time in bits [15:12] and the read strobe in bits [21:16]. All other bits read 0.
- R12: While busy, writes to the control register, to the set alias and to the timing register change nothing. The one exception is clearing the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address (combinational) |

## Verification
The collision that matters is a program request that lands in the same cycle in which a shadow reload finishes. A data write arriving then sees busy still set and must be refused, even though busy drops at that same edge. The bench first loads the key, then starts a reload through the set alias, so the key survives. It then counts cycles so that the data write meets exactly the final reload cycle. The error bit and the unchanged busy are judged there. The same sequence is repeated one cycle later, and there the request must be accepted and run a full program cycle.

// File: rtl/fuse_ctl.sv
`timescale 1ns/1ps
module fuse_ctl #(
  parameter int          NUM_WORDS  = 64,
  parameter int          BANK_WORDS = 8,
  parameter int          HOLE_BANK  = 6,
  parameter int          HOLE_BYTES = 256,
  parameter int          AW         = 12,
  parameter logic [15:0] UNLOCK_KEY = 16'h3E77,
  parameter logic [31:0] TIMING_RST = 32'h0002_2010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata
);

  localparam int WIDX_W = $clog2(NUM_WORDS);
  localparam int SLOT_W = AW - 4;
  localparam logic [SLOT_W-1:0] SH_BASE  = SLOT_W'(64);
  localparam logic [SLOT_W-1:0] HOLE_LO  = SLOT_W'(HOLE_BANK * BANK_WORDS);
  localparam logic [SLOT_W-1:0] HOLE_SZ  = SLOT_W'(HOLE_BYTES / 16);
  localparam logic [SLOT_W-1:0] HOLE_HI  = SLOT_W'(HOLE_BANK * BANK_WORDS + HOLE_BYTES / 16);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(NUM_WORDS + HOLE_BYTES / 16);
  localparam logic [AW-1:0] OFF_CTL = AW'(0);
  localparam logic [AW-1:0] OFF_SET = AW'(4);
  localparam logic [AW-1:0] OFF_TIM = AW'(16);
  localparam logic [AW-1:0] OFF_DAT = AW'(32);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NUM_WORDS - 1);

  logic [6:0]        addr_f;
  logic [15:0]       key;
  logic              err, rl_req, pg_act;
  logic [11:0]       t_prog;
  logic [3:0]        t_relax;
  logic [5:0]        t_rd;
  logic [31:0]       data_r, pg_data;
  logic [WIDX_W-1:0] pg_addr, rl_idx;
  logic [13:0]       pg_cnt;
  logic [5:0]        rl_scnt;
  logic [31:0]       fuse   [NUM_WORDS];
  logic [31:0]       shadow [NUM_WORDS];

  wire busy   = pg_act | rl_req;
  wire wr_ctl = reg_sel & reg_wr & (reg_addr == OFF_CTL);
  wire wr_set = reg_sel & reg_wr & (reg_addr == OFF_SET);
  wire wr_tim = reg_sel & reg_wr & (reg_addr == OFF_TIM);
  wire wr_dat = reg_sel & reg_wr & (reg_addr == OFF_DAT);

  wire [13:0] pg_sum   = {2'b0, t_prog} + {9'b0, t_relax, 1'b0};
  wire [13:0] pg_total = (pg_sum == 14'd0) ? 14'd1 : pg_sum;
  wire [5:0]  rs_eff   = (t_rd == 6'd0) ? 6'd1 : t_rd;
  wire        addr_ok  = {1'b0, addr_f} < 8'(NUM_WORDS);
  wire        pg_ok    = wr_dat & ~busy & ~err & (key == UNLOCK_KEY) & addr_ok;

  wire [SLOT_W-1:0] slot  = reg_addr[AW-1:4] - SH_BASE;
  wire              in_sh = (reg_addr[AW-1:4] >= SH_BASE) && (reg_addr[3:0] == 4'd0) &&
                            ((slot < HOLE_LO) || (slot >= HOLE_HI && slot < SLOT_END));
  wire [WIDX_W-1:0] sh_idx = WIDX_W'((slot < HOLE_LO) ? slot : slot - HOLE_SZ);
  wire [31:0]       ctl_rd = {key, 5'b0, rl_req, err, busy, 1'b0, addr_f};

  always_comb begin
    reg_rdata = '0;
    if (in_sh) reg_rdata = shadow[sh_idx];
    else begin
      case (reg_addr)
        OFF_CTL, OFF_SET: reg_rdata = ctl_rd;
        OFF_TIM:          reg_rdata = {10'b0, t_rd, t_relax, t_prog};
        OFF_DAT:          reg_rdata = data_r;
        default:          reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_f  <= '0;
      key     <= '0;
      err     <= 1'b0;
      rl_req  <= 1'b0;
      pg_act  <= 1'b0;
      t_prog  <= TIMING_RST[11:0];
      t_relax <= TIMING_RST[15:12];
      t_rd    <= TIMING_RST[21:16];
      data_r  <= '0;
      pg_data <= '0;
      pg_addr <= '0;
      rl_idx  <= '0;
      pg_cnt  <= '0;
      rl_scnt <= '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
        fuse[i]   <= '0;
        shadow[i] <= '0;
      end
    end else begin
      if (wr_ctl && reg_wdata[9]) err <= 1'b0;
      if (!busy) begin
        if (wr_ctl) begin
          addr_f <= reg_wdata[6:0];
          key    <= reg_wdata[31:16];
        end
        if (wr_set) begin
          addr_f <= addr_f | reg_wdata[6:0];
          key    <= key | reg_wdata[31:16];
        end
        if (wr_tim) begin
          t_prog  <= reg_wdata[11:0];
          t_relax <= reg_wdata[15:12];
          t_rd    <= reg_wdata[21:16];
        end
        if ((wr_ctl || wr_set) && reg_wdata[10]) begin
          rl_req  <= 1'b1;
          rl_idx  <= '0;
          rl_scnt <= rs_eff;
        end
      end
      if (wr_dat) begin
        key    <= '0;
        data_r <= reg_wdata;
        if (pg_ok) begin
          pg_act  <= 1'b1;
          pg_cnt  <= pg_total;
          pg_addr <= addr_f[WIDX_W-1:0];
          pg_data <= reg_wdata;
        end else begin
          err <= 1'b1;
        end
      end
      if (pg_act) begin
        if (pg_cnt <= 14'd1) begin
          pg_act        <= 1'b0;
          fuse[pg_addr] <= fuse[pg_addr] | pg_data;
        end else begin
          pg_cnt <= pg_cnt - 14'd1;
        end
      end
      if (rl_req) begin
        if (rl_scnt <= 6'd1) begin
          shadow[rl_idx] <= fuse[rl_idx];
          if (rl_idx == LAST_W) rl_req <= 1'b0;
          else begin
            rl_idx  <= rl_idx + 1'b1;
            rl_scnt <= rs_eff;
          end
        end else begin
          rl_scnt <= rl_scnt - 6'd1;
        end
      end
    end
  end

  a_r2_key_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (key == 16'h0));

  a_r4_busy_write_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && busy) |=> err);

  a_r10_err_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && err) |=> !$rose(pg_act));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rl_req |=> ($stable(shadow[0]) && $stable(shadow[NUM_WORDS-1])));

  a_r8_one_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_act && rl_req));

endmodule

// File: tb/sim_fuse_ctl.sv
`timescale 1ns/1ps
module sim_fuse_ctl;
  localparam logic [11:0] CTL = 12'h000, SET = 12'h004, TIM = 12'h010, DAT = 12'h020;
  localparam logic [15:0] KEY = 16'h3E77;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fuse_ctl u0 (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
               .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] v;
    n = 0;
    rd(CTL, v);
    while (v[8]) begin
      n++;
      @(negedge clk);
      rd(CTL, v);
    end
  endtask

  task automatic program_word(input logic [6:0] a, input logic [31:0] d, output int n);
    wr(CTL, {KEY, 9'b0, a});
    wr(DAT, d);
    busy_len(n);
  endtask

  task automatic reload(output int n);
    wr(SET, 32'h0000_0400);
    busy_len(n);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTL, v); chk("R1 ctl", v, 32'h0);
    rd(TIM, v); chk("R1 timing", v, 32'h0002_2010);
    rd(DAT, v); chk("R1 data", v, 32'h0);
    rd(12'h400, v); chk("R1 shadow0", v, 32'h0);
    rd(12'h8F0, v); chk("R1 shadow63", v, 32'h0);
  endtask

  task automatic t_timing;
    logic [31:0] v;
    wr(TIM, 32'hFFFF_FFFF);
    rd(TIM, v); chk("R11 mask", v, 32'h003F_FFFF);
    wr(TIM, 32'h0001_2005);
    rd(TIM, v); chk("R11 fields", v, 32'h0001_2005);
  endtask

  task automatic t_set_alias;
    logic [31:0] v;
    wr(CTL, 32'h0000_0003);
    wr(SET, 32'h0000_0010);
    rd(CTL, v); chk("R3 or addr", v, 32'h0000_0013);
    wr(SET, 32'h3E77_0000);
    rd(CTL, v); chk("R3 or key", v, 32'h3E77_0013);
    wr(CTL, 32'h0);
  endtask

  task automatic t_program_and_stale;
    logic [31:0] v; int n;
    program_word(7'd5, 32'h0000_00A5, n);
    chk("R5 busy cycles", 32'(n), 32'd9);
    rd(CTL, v); chk("R2 key cleared", v, 32'h0000_0005);
    rd(12'h450, v); chk("R7 stale shadow", v, 32'h0);
    reload(n);
    chk("R8 reload cycles", 32'(n), 32'd64);
    rd(CTL, v); chk("R8 request cleared", v & 32'h0000_0700, 32'h0);
    rd(12'h450, v); chk("R7 after reload", v, 32'h0000_00A5);
    program_word(7'd5, 32'h0000_0F00, n);
    rd(12'h450, v); chk("R7 stale again", v, 32'h0000_00A5);
    reload(n);
    rd(12'h450, v); chk("R6 or merge", v, 32'h0000_0FA5);
  endtask

  task automatic t_bad_key_and_err;
    logic [31:0] v; int n;
    wr(CTL, 32'h1234_0006);
    wr(DAT, 32'h0000_00FF);
    rd(CTL, v); chk("R4 bad key error", v, 32'h0000_0206);
    wr(CTL, {KEY, 16'h0006});
    wr(DAT, 32'h0000_00FF);
    rd(CTL, v); chk("R10 ignored while error", v, 32'h0000_0206);
    wr(CTL, 32'h0000_0200);
    rd(CTL, v); chk("R10 error cleared", v, 32'h0);
    reload(n);
    rd(12'h460, v); chk("R4 fuse untouched", v, 32'h0);
  endtask

  task automatic t_busy_writes;
    logic [31:0] v; int n;
    wr(CTL, {KEY, 16'h0007});
    wr(DAT, 32'h0000_0011);
    wr(CTL, 32'h0000_0022);
    wr(TIM, 32'h0);
    wr(DAT, 32'h0000_0022);
    busy_len(n);
    rd(CTL, v); chk("R12 ctl held, R4 busy error", v, 32'h0000_0207);
    rd(TIM, v); chk("R12 timing held", v, 32'h0001_2005);
    wr(CTL, 32'h0000_0207);
    reload(n);
    rd(12'h470, v); chk("R4 only first data", v, 32'h0000_0011);
  endtask

  task automatic t_range;
    logic [31:0] v;
    wr(CTL, {KEY, 16'h0046});
    wr(DAT, 32'h1);
    rd(CTL, v); chk("R4 address out of range", v, 32'h0000_0246);
    wr(CTL, 32'h0000_0200);
  endtask

  task automatic t_hole;
    logic [31:0] v; int n;
    program_word(7'd47, 32'hA0A0_0047, n);
    program_word(7'd48, 32'h0480_0000, n);
    program_word(7'd63, 32'h6300_0063, n);
    reload(n);
    rd(12'h6F0, v); chk("R9 word47", v, 32'hA0A0_0047);
    rd(12'h700, v); chk("R9 gap start", v, 32'h0);
    rd(12'h7F0, v); chk("R9 gap end", v, 32'h0);
    rd(12'h800, v); chk("R9 word48", v, 32'h0480_0000);
    rd(12'h8F0, v); chk("R9 word63", v, 32'h6300_0063);
    rd(12'h900, v); chk("R9 past end", v, 32'h0);
    rd(12'h474, v); chk("R9 unaligned", v, 32'h0);
  endtask

  task automatic t_slow_reload;
    logic [31:0] v; int n;
    wr(TIM, 32'h0003_2005);
    reload(n);
    chk("R8 slow reload cycles", 32'(n), 32'd192);
    rd(CTL, v); chk("R8 request self-clears", v[10], 1'b0);
    wr(TIM, 32'h0001_2005);
  endtask

  task automatic t_reload_edge;
    logic [31:0] v; int n;
    wr(CTL, {KEY, 16'h0009});
    wr(SET, 32'h0000_0400);
    repeat (62) @(negedge clk);
    wr(DAT, 32'h0000_0099);
    rd(CTL, v); chk("R4 last reload cycle refused", v, 32'h0000_0209);
    wr(CTL, {KEY, 16'h0209});
    wr(SET, 32'h0000_0400);
    repeat (63) @(negedge clk);
    wr(DAT, 32'h0000_0099);
    busy_len(n);
    chk("R4 first idle cycle accepted", 32'(n), 32'd9);
    reload(n);
    rd(12'h490, v); chk("R6 word9 programmed", v, 32'h0000_0099);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_set_alias();
    t_program_and_stale();
    t_bad_key_and_err();
    t_busy_writes();
    t_range();
    t_hole();
    t_slow_reload();
    t_reload_edge();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule